// File: doc/BRIEF.md
# External interrupt flag controller

This block watches four external request pins and turns activity on them into sticky status flags. Software sees the flags through a single 16-bit register. Each pin is synchronized into the clock domain, and a two-bit field per pin chooses what raises its flag: a low level, a falling edge, a rising edge, or either edge. Each flag drives one interrupt request output towards the priority logic, which sits outside this block.

A flag stays set until one of three events removes it. Software can clear it with a two-step handshake: it first reads the flag as 1, then writes 0 to it. The exception logic can clear it with an acknowledge pulse for that pin. In low-level mode this acknowledge only clears the flag while the pin is back high. A transfer-controller start pulse for that pin also clears it, unless a global keep control is high. If a new request arrives in the same cycle as any clear, the request wins.

Top module: `xirq_status_unit`

## Requirements
- R1: After a synchronous reset, every flag is 0. Both `irq_req` and `bus_rdata` read 0.
- R2: A read strobe at register address 0 returns the flags in `bus_rdata` in the following cycle, with pin 0 at bit 7, pin 1 at bit 6, pin 2 at bit 5 and pin 3 at bit 4. In any cycle not preceded by such a read, `bus_rdata` is 0.
- R3: Bits 15..8 and 3..0 of the register always read 0. Their value in a write has no effect on any flag.
- R4: The mode field `mode_cfg[2n+1:2n]` selects what sets flag n, judged on the pin after a two-flop synchronizer:
  - 0 sets it while the pin is low.
  - 1 sets it on a falling edge.
  - 2 sets it on a rising edge.
  - 3 sets it on either edge.
- R5: Writing 0 to a flag bit clears that flag only if a register read has returned it as 1 since the last register write. Writing 1 leaves the flag unchanged. Every register write ends the read-as-1 permission for all flags.
- R6: In modes 1, 2 and 3, `exc_ack[n]` clears flag n.
- R7: In mode 0, `exc_ack[n]` clears flag n only when the synchronized pin is high. While the pin is low, the flag stays set.
- R8: `xfer_start[n]` clears flag n when `xfer_keep` is 0. It has no effect when `xfer_keep` is 1.
- R9: When a set condition and any clear request for the same flag occur in the same cycle, the flag is 1 afterwards.
- R10: `irq_req[n]` equals flag n, driven from the flag register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (status register at 0) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | 4 | Asynchronous external request pins |
| mode_cfg | input | 8 | Two-bit detection mode per pin |
| exc_ack | input | 4 | Exception-processing acknowledge per pin |
| xfer_start | input | 4 | Transfer-controller start per pin |
| xfer_keep | input | 1 | When 1, transfer starts do not clear flags |
| irq_req | output | 4 | Interrupt request per pin (registered flag) |

## Verification
The bench builds the block with its default parameters:
- four pins;
- a 16-bit data word;
- flags at bits 7..4;
- a two-stage synchronizer.

Every pin can therefore run in a different detection mode in the same vector. This lets one table row check all four modes against a single pin transition, and a second row repeats the transitions with the modes swapped across pins. Directed steps then reach the corner cases:
- the read-then-write handshake with and without a prior read;
- level-mode acknowledge with the pin low and with it high;
- the keep control;
- a write-0 clear that collides with a held low level.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    DET_LOW  = 2'd0,
    DET_FALL = 2'd1,
    DET_RISE = 2'd2,
    DET_BOTH = 2'd3
  } det_mode_e;
endpackage

// File: rtl/xirq_pin_detect.sv
module xirq_pin_detect
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       pin,
  input  logic [1:0] mode,
  output logic       set_req,
  output logic       pin_high
);
  localparam int LAST = SYNC_STAGES - 1;

  // The synchronizer chain keeps sampling during reset, so the pin level
  // has settled by the time the flags leave reset.
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q[0] <= pin;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk) prev_q <= chain_q[LAST];

  logic fall_ev, rise_ev;
  assign fall_ev  = prev_q & ~chain_q[LAST];
  assign rise_ev  = ~prev_q & chain_q[LAST];
  assign pin_high = chain_q[LAST];

  always_comb begin
    case (det_mode_e'(mode))
      DET_LOW:  set_req = ~chain_q[LAST];
      DET_FALL: set_req = fall_ev;
      DET_RISE: set_req = rise_ev;
      default:  set_req = fall_ev | rise_ev;
    endcase
  end
endmodule

// File: rtl/xirq_flag_cell.sv
module xirq_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic exc_ack,
  input  logic xfer_start,
  input  logic xfer_keep,
  input  logic level_mode,
  input  logic pin_high,
  output logic flag_q
);
  logic arm_q;
  logic clr_wr, clr_exc, clr_xfer, clr_any;

  assign clr_wr   = wr_hit & ~wr_bit & arm_q;
  assign clr_exc  = exc_ack & (~level_mode | pin_high);
  assign clr_xfer = xfer_start & ~xfer_keep;
  assign clr_any  = clr_wr | clr_exc | clr_xfer;

  // A new request wins over any clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_req) flag_q <= 1'b1;
    else if (clr_any) flag_q <= 1'b0;
  end

  // Read-as-1 permission: armed by a read that returns 1, dropped by any write or clear.
  always_ff @(posedge clk) begin
    if (rst)                   arm_q <= 1'b0;
    else if (wr_hit | clr_any) arm_q <= 1'b0;
    else if (rd_hit & flag_q)  arm_q <= 1'b1;
  end
endmodule

// File: rtl/xirq_reg_port.sv
module xirq_reg_port #(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int FLAG_MSB = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [NUM_PINS-1:0] flags,
  output logic                rd_hit,
  output logic                wr_hit,
  output logic [NUM_PINS-1:0] wr_bits,
  output logic [DATA_W-1:0]   bus_rdata
);
  logic              addr_hit;
  logic [DATA_W-1:0] word;

  assign addr_hit = (bus_addr == ADDR_W'(REG_ADDR));
  assign rd_hit   = bus_rd & addr_hit;
  assign wr_hit   = bus_wr & addr_hit;

  // Pin n sits at bit FLAG_MSB-n; all other bits are reserved and read as 0.
  always_comb begin
    word = '0;
    for (int n = 0; n < NUM_PINS; n++) word[FLAG_MSB - n] = flags[n];
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_wb
      assign wr_bits[g] = bus_wdata[FLAG_MSB - g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_hit) bus_rdata <= word;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/xirq_status_unit.sv
module xirq_status_unit
  import xirq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int REG_ADDR    = 0,
  parameter int FLAG_MSB    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic [2*NUM_PINS-1:0] mode_cfg,
  input  logic [NUM_PINS-1:0]   exc_ack,
  input  logic [NUM_PINS-1:0]   xfer_start,
  input  logic                  xfer_keep,
  output logic [NUM_PINS-1:0]   irq_req
);
  logic                rd_hit, wr_hit;
  logic [NUM_PINS-1:0] wr_bits, flags, set_req, pin_high;

  xirq_reg_port #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .REG_ADDR(REG_ADDR), .FLAG_MSB(FLAG_MSB)
  ) u_port (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flags(flags),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .wr_bits(wr_bits),
    .bus_rdata(bus_rdata)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      logic [1:0] mode_n;
      assign mode_n = mode_cfg[2*g +: 2];

      xirq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .pin(pin_in[g]), .mode(mode_n),
        .set_req(set_req[g]), .pin_high(pin_high[g])
      );

      xirq_flag_cell u_cell (
        .clk(clk), .rst(rst), .set_req(set_req[g]),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .wr_bit(wr_bits[g]),
        .exc_ack(exc_ack[g]), .xfer_start(xfer_start[g]),
        .xfer_keep(xfer_keep),
        .level_mode(det_mode_e'(mode_n) == DET_LOW),
        .pin_high(pin_high[g]), .flag_q(flags[g])
      );
    end
  endgenerate

  assign irq_req = flags;
endmodule

// File: rtl/xirq_status_chk.sv
module xirq_status_chk #(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int FLAG_MSB = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] exc_ack,
  input logic [NUM_PINS-1:0] xfer_start,
  input logic                xfer_keep,
  input logic [NUM_PINS-1:0] irq_req
);
  localparam int FLAG_LSB = FLAG_MSB - NUM_PINS + 1;
  localparam logic [DATA_W-1:0] FMASK =
    DATA_W'(((1 << NUM_PINS) - 1) << FLAG_LSB);

  logic hit;
  assign hit = (bus_addr == ADDR_W'(REG_ADDR));

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~FMASK) == '0);

  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && hit) |=> bus_rdata == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_chk
      // R2
      readback_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && hit) |=> bus_rdata[FLAG_MSB - g] == $past(irq_req[g]));

      // R5
      write_one_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && hit && bus_wdata[FLAG_MSB - g] && irq_req[g] &&
         !exc_ack[g] && !(xfer_start[g] && !xfer_keep)) |=> irq_req[g]);

      // R8
      keep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_start[g] && xfer_keep && irq_req[g] && !bus_wr && !exc_ack[g])
        |=> irq_req[g]);

      // R5
      clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_req[g]) |-> $past(bus_wr || exc_ack[g] || xfer_start[g]));
    end
  endgenerate
endmodule

bind xirq_status_unit xirq_status_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REG_ADDR(REG_ADDR), .FLAG_MSB(FLAG_MSB)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .exc_ack(exc_ack), .xfer_start(xfer_start), .xfer_keep(xfer_keep),
  .irq_req(irq_req)
);

// File: tb/tb_xirq_status_unit.sv
module tb_xirq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  pin_in = 4'hF;
  logic [7:0]  mode_cfg = 8'hE4;
  logic [3:0]  exc_ack = '0, xfer_start = '0;
  logic        xfer_keep = 1'b0;
  logic [3:0]  irq_req;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xirq_status_unit dut (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .mode_cfg(mode_cfg), .exc_ack(exc_ack),
    .xfer_start(xfer_start), .xfer_keep(xfer_keep), .irq_req(irq_req)
  );

  // {modes[7:0], pin before, pin after, expected irq_req[3:0]}
  // mode encoding: 0 low, 1 fall, 2 rise, 3 both; E4 = pin0 low..pin3 both, 1B reversed
  localparam logic [13:0] VEC [NVEC] = '{
    {8'hE4, 1'b1, 1'b1, 4'b0000},
    {8'hE4, 1'b1, 1'b0, 4'b1011},
    {8'hE4, 1'b0, 1'b1, 4'b1101},
    {8'hE4, 1'b0, 1'b0, 4'b0001},
    {8'h1B, 1'b1, 1'b1, 4'b0000},
    {8'h1B, 1'b1, 1'b0, 4'b1101},
    {8'h1B, 1'b0, 1'b1, 4'b1011},
    {8'h1B, 1'b0, 1'b0, 4'b1000}
  };

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_read();
    bus_rd = 1'b1; tick(); bus_rd = 1'b0;
  endtask

  task automatic reg_write(logic [15:0] d);
    bus_wdata = d; bus_wr = 1'b1; tick(); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse_exc(logic [3:0] m);
    exc_ack = m; tick(); exc_ack = '0;
  endtask

  task automatic pulse_xfer(logic [3:0] m);
    xfer_start = m; tick(); xfer_start = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    tick(4);
    // R1: reset state
    check("R1 irq", {12'h0, irq_req}, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    rst = 1'b0;

    // R4 / R10: table of pin transitions against all modes
    for (int i = 0; i < NVEC; i++) begin
      mode_cfg = VEC[i][13:6];
      pin_in = {4{VEC[i][5]}};
      rst = 1'b1; tick(4); rst = 1'b0; tick(2);
      pin_in = {4{VEC[i][4]}};
      tick(5);
      check($sformatf("R4 R10 vec%0d", i), {12'h0, irq_req}, {12'h0, VEC[i][3:0]});
    end

    // Directed: pin0 low, pin1 fall, pin2 rise, pin3 both
    mode_cfg = 8'hE4; pin_in = 4'hF;
    rst = 1'b1; tick(4); rst = 1'b0; tick(2);
    pin_in = 4'h0; tick(5);
    pin_in = 4'hF; tick(5);
    check("R4 all set", {12'h0, irq_req}, 16'h000F);

    reg_write(16'h0000);
    check("R5 write0 without read", {12'h0, irq_req}, 16'h000F);
    reg_read();
    check("R2 R3 readback", bus_rdata, 16'h00F0);
    tick();
    check("R2 idle rdata", bus_rdata, 16'h0000);

    reg_write(16'hFFBF);
    check("R5 clear pin1", {12'h0, irq_req}, 16'h000D);
    reg_read();
    check("R2 readback after clear", bus_rdata, 16'h00B0);
    reg_write(16'hFFFF);
    check("R5 write1 keeps", {12'h0, irq_req}, 16'h000D);
    reg_write(16'h0000);
    check("R5 disarmed by write", {12'h0, irq_req}, 16'h000D);

    pulse_exc(4'b0100);
    check("R6 edge ack", {12'h0, irq_req}, 16'h0009);
    pulse_exc(4'b0001);
    check("R7 level ack pin high", {12'h0, irq_req}, 16'h0008);

    xfer_keep = 1'b1;
    pulse_xfer(4'b1000);
    check("R8 keep", {12'h0, irq_req}, 16'h0008);
    xfer_keep = 1'b0;
    pulse_xfer(4'b1000);
    check("R8 clear", {12'h0, irq_req}, 16'h0000);

    pin_in = 4'hE; tick(5);
    check("R4 level set", {12'h0, irq_req}, 16'h0001);
    pulse_exc(4'b0001);
    check("R7 level ack pin low", {12'h0, irq_req}, 16'h0001);
    reg_read();
    reg_write(16'hFF0F);
    check("R9 set wins over write clear", {12'h0, irq_req}, 16'h0001);
    reg_read();
    check("R3 reserved zero", bus_rdata, 16'h0080);

    pin_in = 4'hF; tick(5);
    reg_read();
    reg_write(16'hFF7F);
    check("R5 handshake clear", {12'h0, irq_req}, 16'h0000);

    done = 1;
    finish_run();
  end
endmodule